// File: doc/BRIEF.md
# Touch Toggle Output with Auto-Off Timer

This block sits behind a touch-sensing front end and owns the switched output. Each confirmed touch event flips the output between its on and off states. While the output is on, a countdown can switch it off after a preset delay. The delay is either a short preset, a long preset, or no limit at all, and a multiplier chosen once after reset can stretch the short and long presets.

An override line lets surrounding logic change the countdown. The line is looked at only at the end of each acquisition cycle, and measurement bursts are held off for as long as the sampled level is active. The block counts how long the override is held, in millisecond ticks. A hold of moderate length reloads the countdown when it is released. A hold that reaches the long threshold switches the output off at once, and touches stay ignored until the line returns to idle. Every release asks the sensor to recalibrate. A recalibration request that comes from stuck-detection logic is passed on to the same request output and leaves the output state alone.

Top module: `toggle_autooff_ctrl`

## Requirements
- R1: Each `touch_i` pulse inverts the internal on state, provided the sampled override is idle. The output changes on the clock edge that samples the pulse.
- R2: With OUT_ACT_HIGH=1 the pin is high when on. With OUT_ACT_HIGH=0 the pin is low when on. After reset the state is off.
- R3: `dly_sel_i` encoding: 2'b01 selects the short preset, 2'b10 the long preset, and 2'b00 or 2'b11 selects no limit. With a finite preset, the output turns off on the edge that samples the L-th `tick_i` counted after turn-on, where L is the preset multiplied by the multiplier. With no limit, ticks never turn it off.
- R4: `mult_sel_i` is captured on the first clock after reset release. A captured 1 gives the multiplier MULT_HI and a captured 0 gives 1. Later changes on `mult_sel_i` are ignored.
- R5: `ovr_i` is sampled only in cycles where `acq_end_i` is high. `burst_inhibit_o` equals the sampled level, and it starts at 0 after reset.
- R6: While the sampled override is active, each `ms_tick_i` adds one to a width count W. On release, if RELOAD_MS <= W < CANCEL_MS and the output is on, the countdown restarts from its full value L. If W < RELOAD_MS, the output and the countdown are left unchanged.
- R7: When W reaches CANCEL_MS, the output goes off on that same edge. Touches are ignored for as long as the sampled override stays active.
- R8: Every release of the sampled override raises `recal_req_o` for exactly one cycle, in the cycle after the release edge. The output state is kept.
- R9: A `stuck_recal_i` pulse raises `recal_req_o` in the following cycle and leaves the output state unchanged.
- R10: While the output is off the countdown does not run. Each turn-on starts a full delay of L ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_i | input | 1 | One-cycle pulse for a confirmed touch |
| dly_sel_i | input | 2 | Preset select (01 short, 10 long, 00/11 no limit) |
| mult_sel_i | input | 1 | Multiplier select, captured once after reset |
| ovr_i | input | 1 | Override level, active high |
| acq_end_i | input | 1 | End-of-acquisition strobe that samples the override |
| ms_tick_i | input | 1 | Millisecond tick used to measure override width |
| tick_i | input | 1 | Countdown tick |
| stuck_recal_i | input | 1 | Recalibration request from stuck-detection logic |
| out_pin_o | output | 1 | Switched output after polarity is applied |
| burst_inhibit_o | output | 1 | Holds off measurement bursts |
| recal_req_o | output | 1 | One-cycle recalibration request |

## Verification
The bench builds two copies of the block with SHORT_TICKS=3, LONG_TICKS=5, MULT_HI=4, RELOAD_MS=2 and CANCEL_MS=5. The two copies differ only in output polarity. With such short delays, every preset code can be run to expiry under both multiplier values, and the boundary tick can be checked exactly. Override widths from 0 to 7 ticks cover the cases below the reload threshold, inside the reload window, at the cancel threshold and beyond it.

// File: rtl/tgl_pkg.sv
package tgl_pkg;

   typedef enum logic [1:0] {
      DLY_FOREVER = 2'b00,
      DLY_SHORT   = 2'b01,
      DLY_LONG    = 2'b10,
      DLY_FOREVER_ALT = 2'b11
   } dly_sel_e;

   function automatic logic dly_is_finite(dly_sel_e s);
      return (s == DLY_SHORT) || (s == DLY_LONG);
   endfunction

endpackage

// File: rtl/tgl_mult_latch.sv
module tgl_mult_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mult_sel_i,
   output logic mult_hi_o
);
   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q   <= 1'b0;
         mult_hi_o <= 1'b0;
      end else if (!armed_q) begin
         armed_q   <= 1'b1;
         mult_hi_o <= mult_sel_i;
      end
   end

   // R4: once captured, the selection never moves
   a_r4_mult_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q |=> $stable(mult_hi_o));

endmodule

// File: rtl/tgl_ovr_classify.sv
module tgl_ovr_classify #(
   parameter int RELOAD_MS = 35,
   parameter int CANCEL_MS = 75
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic acq_end_i,
   input  logic ovr_i,
   input  logic ms_tick_i,
   output logic held_o,
   output logic reload_o,
   output logic cancel_o,
   output logic release_o
);
   localparam int PW_W = $clog2(CANCEL_MS + 1);
   localparam logic [PW_W-1:0] PW_RELOAD = PW_W'(RELOAD_MS);
   localparam logic [PW_W-1:0] PW_CANCEL = PW_W'(CANCEL_MS);
   localparam logic [PW_W-1:0] PW_LAST   = PW_W'(CANCEL_MS - 1);

   logic [PW_W-1:0] pw_q;
   logic            held_q;
   logic            start;

   assign start = acq_end_i && ovr_i && !held_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= 1'b0;
      end else if (acq_end_i) begin
         held_q <= ovr_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pw_q <= '0;
      end else if (start) begin
         pw_q <= '0;
      end else if (held_q && ms_tick_i && (pw_q < PW_CANCEL)) begin
         pw_q <= pw_q + 1'b1;
      end
   end

   assign held_o    = held_q;
   assign release_o = held_q && acq_end_i && !ovr_i;
   assign cancel_o  = held_q && ms_tick_i && (pw_q == PW_LAST);
   assign reload_o  = release_o && (pw_q >= PW_RELOAD) && (pw_q < PW_CANCEL);

   // R5: sampled override moves only on the acquisition strobe
   a_r5_sample_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acq_end_i |=> $stable(held_o));

   // R7: the cancel threshold is crossed at most once per hold
   a_r7_cancel_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cancel_o |=> !cancel_o);

   // R6: the width count never runs past the cancel threshold
   a_r6_width_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pw_q <= PW_CANCEL);

endmodule

// File: rtl/tgl_countdown.sv
module tgl_countdown
   import tgl_pkg::*;
#(
   parameter int SHORT_TICKS = 900,
   parameter int LONG_TICKS  = 3600,
   parameter int MULT_HI     = 24
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  dly_sel_e dly_sel_i,
   input  logic     mult_hi_i,
   input  logic     run_i,
   input  logic     load_i,
   input  logic     tick_i,
   output logic     expire_o
);
   localparam int MAX_TICKS = LONG_TICKS * MULT_HI;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_TICKS);
   localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(SHORT_TICKS);
   localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LONG_TICKS);
   localparam bit   MULT_POW2 = ((MULT_HI & (MULT_HI - 1)) == 0);

   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] scaled;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic             finite;

   assign finite = dly_is_finite(dly_sel_i);

   always_comb begin
      unique case (dly_sel_i)
         DLY_SHORT: base = CNT_SHORT;
         DLY_LONG:  base = CNT_LONG;
         default:   base = '0;
      endcase
   end

   generate
      if (MULT_POW2) begin : g_mul_shift
         localparam int SH = $clog2(MULT_HI);
         assign scaled = base << SH;
      end else begin : g_mul_full
         assign scaled = base * CNT_W'(MULT_HI);
      end
   endgenerate

   assign load_val = mult_hi_i ? scaled : base;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val;
      end else if (run_i && finite && tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = run_i && finite && tick_i && (cnt_q == CNT_W'(1));

   // R10: no counting while the output is off
   a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !load_i) |=> $stable(cnt_q));

   // R3: the count stays within the largest delay
   a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_MAX);

endmodule

// File: rtl/toggle_autooff_ctrl.sv
module toggle_autooff_ctrl
   import tgl_pkg::*;
#(
   parameter bit OUT_ACT_HIGH = 1'b1,
   parameter int SHORT_TICKS  = 900,
   parameter int LONG_TICKS   = 3600,
   parameter int MULT_HI      = 24,
   parameter int RELOAD_MS    = 35,
   parameter int CANCEL_MS    = 75
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       touch_i,
   input  logic [1:0] dly_sel_i,
   input  logic       mult_sel_i,
   input  logic       ovr_i,
   input  logic       acq_end_i,
   input  logic       ms_tick_i,
   input  logic       tick_i,
   input  logic       stuck_recal_i,
   output logic       out_pin_o,
   output logic       burst_inhibit_o,
   output logic       recal_req_o
);
   generate
      if (SHORT_TICKS < 1) begin : g_chk_short
         $error("SHORT_TICKS must be at least 1");
      end
      if (LONG_TICKS < SHORT_TICKS) begin : g_chk_long
         $error("LONG_TICKS must not be below SHORT_TICKS");
      end
      if (MULT_HI < 2) begin : g_chk_mult
         $error("MULT_HI must be at least 2");
      end
      if (RELOAD_MS < 1 || CANCEL_MS <= RELOAD_MS) begin : g_chk_ovr
         $error("override thresholds must satisfy 1 <= RELOAD_MS < CANCEL_MS");
      end
   endgenerate

   logic on_q, on_n;
   logic mult_hi;
   logic held, reload, cancel, rel;
   logic expire, touch_eff, turn_on, load;
   logic recal_q;

   tgl_mult_latch u_mult (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mult_sel_i (mult_sel_i),
      .mult_hi_o  (mult_hi)
   );

   tgl_ovr_classify #(
      .RELOAD_MS (RELOAD_MS),
      .CANCEL_MS (CANCEL_MS)
   ) u_ovr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acq_end_i (acq_end_i),
      .ovr_i     (ovr_i),
      .ms_tick_i (ms_tick_i),
      .held_o    (held),
      .reload_o  (reload),
      .cancel_o  (cancel),
      .release_o (rel)
   );

   tgl_countdown #(
      .SHORT_TICKS (SHORT_TICKS),
      .LONG_TICKS  (LONG_TICKS),
      .MULT_HI     (MULT_HI)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dly_sel_i (dly_sel_e'(dly_sel_i)),
      .mult_hi_i (mult_hi),
      .run_i     (on_q),
      .load_i    (load),
      .tick_i    (tick_i),
      .expire_o  (expire)
   );

   assign touch_eff = touch_i && !held;

   always_comb begin
      on_n = on_q ^ touch_eff;
      if (expire) on_n = 1'b0;
      if (cancel) on_n = 1'b0;
   end

   assign turn_on = !on_q && on_n;
   assign load    = turn_on || (reload && on_q && on_n);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         on_q    <= 1'b0;
         recal_q <= 1'b0;
      end else begin
         on_q    <= on_n;
         recal_q <= rel || stuck_recal_i;
      end
   end

   generate
      if (OUT_ACT_HIGH) begin : g_out_high
         assign out_pin_o = on_q;
      end else begin : g_out_low
         assign out_pin_o = !on_q;
      end
   endgenerate

   assign burst_inhibit_o = held;
   assign recal_req_o     = recal_q;

   // R1: an accepted touch flips the state
   a_r1_touch_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (touch_i && !held && !cancel && !expire) |=> (on_q != $past(on_q)));

   // R7: crossing the cancel width leaves the output off
   a_r7_cancel_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cancel |=> !on_q);

   // R7: touches have no effect while the override is held
   a_r7_touch_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (held && !cancel && !expire) |=> $stable(on_q));

   // R8: release is followed by a recalibration request
   a_r8_release_recal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel |=> recal_req_o);

   // R9: a stuck recalibration leaves the state alone
   a_r9_stuck_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stuck_recal_i && !touch_i && !cancel && !expire) |=> $stable(on_q));

endmodule

// File: tb/toggle_autooff_ctrl_tb.sv
module toggle_autooff_ctrl_tb_top;

   localparam int SHORT = 3;
   localparam int LONG  = 5;
   localparam int MHI   = 4;
   localparam int RLD   = 2;
   localparam int CNC   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic touch = 1'b0, msel = 1'b0, ovr = 1'b0, acq = 1'b0;
   logic mst = 1'b0, tick = 1'b0, stuck = 1'b0;
   logic [1:0] dsel = 2'b00;
   logic out_h, inh_h, rec_h, out_l, inh_l, rec_l;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   toggle_autooff_ctrl #(
      .OUT_ACT_HIGH(1'b1), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG),
      .MULT_HI(MHI), .RELOAD_MS(RLD), .CANCEL_MS(CNC)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .touch_i(touch), .dly_sel_i(dsel),
      .mult_sel_i(msel), .ovr_i(ovr), .acq_end_i(acq), .ms_tick_i(mst),
      .tick_i(tick), .stuck_recal_i(stuck), .out_pin_o(out_h),
      .burst_inhibit_o(inh_h), .recal_req_o(rec_h)
   );

   toggle_autooff_ctrl #(
      .OUT_ACT_HIGH(1'b0), .SHORT_TICKS(SHORT), .LONG_TICKS(LONG),
      .MULT_HI(MHI), .RELOAD_MS(RLD), .CANCEL_MS(CNC)
   ) dut_lo_i (
      .clk_i(clk), .rst_ni(rst_n), .touch_i(touch), .dly_sel_i(dsel),
      .mult_sel_i(msel), .ovr_i(ovr), .acq_end_i(acq), .ms_tick_i(mst),
      .tick_i(tick), .stuck_recal_i(stuck), .out_pin_o(out_l),
      .burst_inhibit_o(inh_l), .recal_req_o(rec_l)
   );

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // R2: both polarities follow the same state
   task automatic chk_on(string tag, logic exp_on);
      chk({tag, " R2 high"}, out_h, exp_on);
      chk({tag, " R2 low"}, out_l, ~exp_on);
   endtask

   task automatic do_reset(logic m);
      @(negedge clk);
      rst_n = 1'b0; msel = m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      msel = ~m;   // R4: later change must be ignored
   endtask

   task automatic touch_p();
      @(negedge clk) touch = 1'b1;
      @(negedge clk) touch = 1'b0;
   endtask

   task automatic tick_n(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic ms_n(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) mst = 1'b1;
         @(negedge clk) mst = 1'b0;
      end
   endtask

   task automatic acq_p(logic v);
      @(negedge clk); ovr = v; acq = 1'b1;
      @(negedge clk); acq = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         total++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
         $finish;
      end
   end

   initial begin
      // reset state
      do_reset(1'b0);
      chk_on("reset", 1'b0);
      chk("reset R5 inhibit", inh_h, 1'b0);
      chk("reset R8 recal", rec_h, 1'b0);

      // preset and multiplier sweep: R1 R3 R4 R10
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            int len;
            do_reset(m[0]);
            dsel = s[1:0];
            len = (s == 1) ? SHORT : (s == 2) ? LONG : 0;
            if (m == 1) len = len * MHI;
            touch_p();
            chk_on("R1 touch on", 1'b1);
            if (len == 0) begin
               tick_n(25);
               chk_on("R3 no limit holds", 1'b1);
               touch_p();
               chk_on("R1 touch off", 1'b0);
               tick_n(4);
               chk_on("R10 idle stays off", 1'b0);
            end else begin
               tick_n(len - 1);
               chk_on("R3 R4 before expiry", 1'b1);
               tick_n(1);
               chk_on("R3 R4 at expiry", 1'b0);
               tick_n(7);
               chk_on("R10 idle stays off", 1'b0);
               touch_p();
               chk_on("R10 turn on again", 1'b1);
               tick_n(len - 1);
               chk_on("R10 full delay before", 1'b1);
               tick_n(1);
               chk_on("R10 full delay at end", 1'b0);
            end
         end
      end

      // override width sweep: R5 R6 R7 R8
      for (int w = 0; w < 8; w++) begin
         logic exp_on;
         do_reset(1'b0);
         dsel = 2'b01;
         touch_p();
         tick_n(2);              // one tick left
         @(negedge clk) ovr = 1'b1;
         @(negedge clk);
         chk("R5 no strobe no sample", inh_h, 1'b0);
         acq_p(1'b1);
         chk("R5 inhibit on", inh_h, 1'b1);
         ms_n(w);
         exp_on = (w < CNC);
         chk_on("R7 cancel width", exp_on);
         touch_p();
         chk_on("R7 touch ignored", exp_on);
         acq_p(1'b0);
         chk("R8 recal pulse", rec_h, 1'b1);
         chk("R5 inhibit off", inh_h, 1'b0);
         chk_on("R8 state kept", exp_on);
         @(negedge clk);
         chk("R8 recal single", rec_h, 1'b0);
         if (w >= CNC) begin
            tick_n(3);
            chk_on("R7 stays off", 1'b0);
         end else if (w >= RLD) begin
            tick_n(SHORT - 1);
            chk_on("R6 reloaded before", 1'b1);
            tick_n(1);
            chk_on("R6 reloaded end", 1'b0);
         end else begin
            tick_n(1);
            chk_on("R6 short pulse no reload", 1'b0);
         end
      end

      // stuck recalibration: R9
      do_reset(1'b0);
      dsel = 2'b00;
      touch_p();
      @(negedge clk) stuck = 1'b1;
      @(negedge clk) stuck = 1'b0;
      chk("R9 recal raised", rec_h, 1'b1);
      chk_on("R9 state kept", 1'b1);
      @(negedge clk);
      chk("R9 recal single", rec_h, 1'b0);
      chk_on("R9 state still kept", 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

endmodule